// File: doc/BRIEF.md
# Threshold-Driven Data FIFO

This block is a 32-word, 16-bit circular buffer placed between a register-mapped host data port and the word stream of a card engine. The host pushes words by writing its data register and pops them by reading it. The card engine pushes and pops through a plain strobe interface. The occupancy is kept in a register and exported. It is compared with two programmable levels: an almost-full level for the receive direction (card to host) and an almost-empty level for the transmit direction (host to card).

Each direction reports its threshold condition in one of two ways. It can set a polled status flag, or it can assert a DMA request line. A per-direction DMA enable in the configuration word selects which.

A small transfer controller tracks whether a data transfer is running and in which direction. It has three states. In ST_IDLE no transfer is running. ST_RECV is a receive transfer and ST_XMIT a transmit transfer. A `xfer_start` pulse moves the controller to ST_RECV when `xfer_rx` is 1 and to ST_XMIT when it is 0, from any state. The same pulse empties the buffer. A `xfer_end` pulse returns ST_RECV or ST_XMIT to ST_IDLE. In ST_IDLE the direction of the last transfer is kept. If `xfer_start` and `xfer_end` arrive in the same cycle, `xfer_start` wins.

Top module: `thresh_fifo`

## Requirements
- R1: After reset, the occupancy is 0. The almost-full level is 31, the almost-empty level is 0 and both DMA enables are off, so `cfg_rdata` reads 16'h1F00. All four request and flag outputs are low.
- R2: Accepted words leave the buffer in the order they entered, and the indices wrap modulo 32. A cycle that both accepts a push and performs a pop leaves the occupancy unchanged. The occupancy changes one cycle after the strobe that caused the change.
- R3: A push, from either side, is dropped when the occupancy is already 32. This holds even if a pop happens in the same cycle. A dropped push changes neither the contents nor the occupancy.
- R4: A pop of an empty buffer changes nothing, and `head_word` keeps showing the word stored at the head index. The next accepted push becomes the head word.
- R5: In the receive direction, with occupancy strictly above the almost-full level, the block does one of two things. With receive DMA enabled, `rx_dma_req` is 1 and `af_flag` is 0. With it disabled, `af_flag` is 1 and `rx_dma_req` is 0.
- R6: In the transmit direction, with occupancy strictly below the almost-empty level, the block does one of two things. With transmit DMA enabled, `tx_dma_req` is 1 and `ae_flag` is 0. With it disabled, `ae_flag` is 1 and `tx_dma_req` is 0.
- R7: A direction whose threshold condition is false has both its request and its flag low. The same holds for the direction that is not the current one.
- R8: In ST_IDLE with an empty buffer, all four request and flag outputs are low whatever the levels are. In ST_IDLE with words left, the thresholds are still evaluated in the last direction.
- R9: The configuration word has these fields: bit 15 enables receive DMA, bits 12:8 hold the almost-full level, bit 7 enables transmit DMA and bits 4:0 hold the almost-empty level. The remaining bits are ignored and read back as 0.
- R10: A configuration write that sets a DMA enable clears that direction's flag from the next cycle on. The request takes the flag's place if the condition holds.
- R11: A `xfer_start` pulse sets the occupancy to 0 in the next cycle. Any push or pop in that same cycle is discarded.
- R12: When the host and the card both push in one cycle, only the card's word is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host writes the data register (push) |
| host_wdata | input | 16 | Word written by the host |
| host_rd | input | 1 | Host reads the data register (pop) |
| card_push | input | 1 | Card engine pushes a word |
| card_wdata | input | 16 | Word pushed by the card engine |
| card_pop | input | 1 | Card engine pops a word |
| head_word | output | 16 | Word at the head index, read data for both sides |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 16 | Configuration word written |
| cfg_rdata | output | 16 | Configuration word read back |
| xfer_start | input | 1 | Start a data transfer and empty the buffer |
| xfer_rx | input | 1 | Direction of the started transfer, 1 = receive |
| xfer_end | input | 1 | The running transfer has finished |
| fill_level | output | 6 | Current occupancy, 0 to 32 |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| af_flag | output | 1 | Almost-full status flag |
| ae_flag | output | 1 | Almost-empty status flag |

## Verification
The bench aims at the edges of the occupancy range. Filling to exactly 32 and pushing once more catches a full test off by one, which would overwrite the oldest word. Draining across the wrap catches index arithmetic that is not modulo 32, which would return words out of order. Popping an empty buffer catches a design that moves the head anyway, which would then return a stale word after the next push.

Each threshold is probed at equality. Occupancy equal to the level must not trigger, so a comparison with the wrong strictness shows up as a flag one word early. The DMA enables are switched while the condition holds: a design that keeps the flag beside the request, or drops the request, fails at once.

The idle-and-empty gate is checked in both states. An almost-empty level above zero with no transfer must stay silent. An idle buffer that still holds words must still request, which catches a gate that looks only at the controller state.

// File: rtl/thf_pkg.sv
package thf_pkg;
    // Field placement inside the 16-bit configuration word
    localparam int CFG_W    = 16;
    localparam int LVL_W    = 5;
    localparam int RXEN_BIT = 15;
    localparam int AF_LSB   = 8;
    localparam int TXEN_BIT = 7;
    localparam int AE_LSB   = 0;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RECV = 2'd1,
        ST_XMIT = 2'd2
    } xfer_state_e;

    typedef struct packed {
        logic             rx_dma_en;
        logic [LVL_W-1:0] af_lvl;
        logic             tx_dma_en;
        logic [LVL_W-1:0] ae_lvl;
    } thr_cfg_t;
endpackage

// File: rtl/thf_cfg.sv
module thf_cfg
    import thf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    output thr_cfg_t         cfg,
    output logic [CFG_W-1:0] cfg_rdata
);
    // R1 reset values, R9 field layout
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '{rx_dma_en: 1'b0, af_lvl: '1, tx_dma_en: 1'b0, ae_lvl: '0};
        end else if (cfg_we) begin
            cfg <= '{rx_dma_en: cfg_wdata[RXEN_BIT],
                     af_lvl:    cfg_wdata[AF_LSB +: LVL_W],
                     tx_dma_en: cfg_wdata[TXEN_BIT],
                     ae_lvl:    cfg_wdata[AE_LSB +: LVL_W]};
        end
    end

    always_comb begin
        cfg_rdata                     = '0;
        cfg_rdata[RXEN_BIT]           = cfg.rx_dma_en;
        cfg_rdata[AF_LSB +: LVL_W]    = cfg.af_lvl;
        cfg_rdata[TXEN_BIT]           = cfg.tx_dma_en;
        cfg_rdata[AE_LSB +: LVL_W]    = cfg.ae_lvl;
    end
endmodule

// File: rtl/thf_ctrl.sv
module thf_ctrl
    import thf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic xfer_start,
    input  logic xfer_rx,
    input  logic xfer_end,
    output logic busy,
    output logic dir_rx
);
    xfer_state_e state_q, state_d;
    logic        last_rx_q;

    // next-state selection; a start pulse outranks an end pulse
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (xfer_start) state_d = xfer_rx ? ST_RECV : ST_XMIT;
            end
            ST_RECV, ST_XMIT: begin
                if (xfer_start)    state_d = xfer_rx ? ST_RECV : ST_XMIT;
                else if (xfer_end) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            last_rx_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            if (xfer_start) last_rx_q <= xfer_rx;
        end
    end

    // outputs; the idle state keeps the last transfer direction (R8)
    always_comb begin
        busy   = 1'b0;
        dir_rx = last_rx_q;
        unique case (state_q)
            ST_IDLE: begin
                busy   = 1'b0;
                dir_rx = last_rx_q;
            end
            ST_RECV: begin
                busy   = 1'b1;
                dir_rx = 1'b1;
            end
            ST_XMIT: begin
                busy   = 1'b1;
                dir_rx = 1'b0;
            end
            default: begin
                busy   = 1'b0;
                dir_rx = last_rx_q;
            end
        endcase
    end
endmodule

// File: rtl/thf_store.sv
module thf_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CNT_W-1:0]  count
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              do_push, do_pop;

    // R3 full push dropped, R4 empty pop ignored, R11 clear wins
    assign do_push = push && (count != FULL_CNT) && !clr;
    assign do_pop  = pop  && (count != '0)       && !clr;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    assign head_data = mem[rd_ptr];
endmodule

// File: rtl/thf_route.sv
module thf_route (
    input  logic quiet,
    input  logic cond,
    input  logic dma_en,
    output logic req,
    output logic flag
);
    // one direction: the condition goes to the request or to the flag
    always_comb begin
        req  = 1'b0;
        flag = 1'b0;
        if (!quiet && cond) begin
            if (dma_en) req  = 1'b1;
            else        flag = 1'b1;
        end
    end
endmodule

// File: rtl/thf_level.sv
module thf_level
    import thf_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic [CNT_W-1:0] count,
    input  logic             busy,
    input  logic             dir_rx,
    input  thr_cfg_t         cfg,
    output logic             rx_req,
    output logic             tx_req,
    output logic             af_flag,
    output logic             ae_flag
);
    logic             quiet;
    logic [1:0]       cond, en, req, flg;
    logic [CNT_W-1:0] af_ext, ae_ext;

    assign af_ext = CNT_W'(cfg.af_lvl);
    assign ae_ext = CNT_W'(cfg.ae_lvl);
    // R8 no transfer and nothing stored: silence both directions
    assign quiet  = !busy && (count == '0);
    // R5 / R6 strict comparisons, R7 direction match
    assign cond[0] = dir_rx  && (count > af_ext);
    assign cond[1] = !dir_rx && (count < ae_ext);
    assign en[0]   = cfg.rx_dma_en;
    assign en[1]   = cfg.tx_dma_en;

    for (genvar d = 0; d < 2; d++) begin : g_dir
        thf_route u_route (
            .quiet  (quiet),
            .cond   (cond[d]),
            .dma_en (en[d]),
            .req    (req[d]),
            .flag   (flg[d])
        );
    end

    assign rx_req  = req[0];
    assign af_flag = flg[0];
    assign tx_req  = req[1];
    assign ae_flag = flg[1];
endmodule

// File: rtl/thresh_fifo.sv
module thresh_fifo
    import thf_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   host_wr,
    input  logic [DATA_W-1:0]      host_wdata,
    input  logic                   host_rd,
    input  logic                   card_push,
    input  logic [DATA_W-1:0]      card_wdata,
    input  logic                   card_pop,
    output logic [DATA_W-1:0]      head_word,
    input  logic                   cfg_we,
    input  logic [CFG_W-1:0]       cfg_wdata,
    output logic [CFG_W-1:0]       cfg_rdata,
    input  logic                   xfer_start,
    input  logic                   xfer_rx,
    input  logic                   xfer_end,
    output logic [$clog2(DEPTH):0] fill_level,
    output logic                   rx_dma_req,
    output logic                   tx_dma_req,
    output logic                   af_flag,
    output logic                   ae_flag
);
    localparam int CNT_W = $clog2(DEPTH) + 1;

    thr_cfg_t          cfg;
    logic              xfer_busy, dir_rx;
    logic              any_push, any_pop;
    logic [DATA_W-1:0] push_word;

    // R12 card word has priority over the host word
    assign any_push  = host_wr || card_push;
    assign push_word = card_push ? card_wdata : host_wdata;
    assign any_pop   = host_rd || card_pop;

    thf_cfg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg       (cfg),
        .cfg_rdata (cfg_rdata)
    );

    thf_ctrl u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .xfer_start (xfer_start),
        .xfer_rx    (xfer_rx),
        .xfer_end   (xfer_end),
        .busy       (xfer_busy),
        .dir_rx     (dir_rx)
    );

    thf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (xfer_start),
        .push      (any_push),
        .push_data (push_word),
        .pop       (any_pop),
        .head_data (head_word),
        .count     (fill_level)
    );

    thf_level #(.CNT_W(CNT_W)) u_level (
        .count   (fill_level),
        .busy    (xfer_busy),
        .dir_rx  (dir_rx),
        .cfg     (cfg),
        .rx_req  (rx_dma_req),
        .tx_req  (tx_dma_req),
        .af_flag (af_flag),
        .ae_flag (ae_flag)
    );
endmodule

// File: rtl/thresh_fifo_chk.sv
module thresh_fifo_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 32,
    localparam int CNT_W = $clog2(DEPTH) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_wr,
    input logic              host_rd,
    input logic              card_push,
    input logic              card_pop,
    input logic              xfer_start,
    input logic              xfer_busy,
    input logic              cfg_we,
    input logic              cfg_rxen_bit,
    input logic              cfg_txen_bit,
    input logic [DATA_W-1:0] head_word,
    input logic [CNT_W-1:0]  fill_level,
    input logic              rx_dma_req,
    input logic              tx_dma_req,
    input logic              af_flag,
    input logic              ae_flag
);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    // R3
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= FULL_CNT);

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == FULL_CNT && !host_rd && !card_pop && !xfer_start)
        |=> (fill_level == FULL_CNT && $stable(head_word)));

    // R4
    empty_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill_level == '0 && !host_wr && !card_push && !xfer_start)
        |=> (fill_level == '0 && $stable(head_word)));

    // R2
    unit_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !xfer_start |=> (fill_level == $past(fill_level)
                      || fill_level == $past(fill_level) + CNT_W'(1)
                      || fill_level == $past(fill_level) - CNT_W'(1)));

    // R5
    rx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rx_dma_req && af_flag));

    // R6
    tx_route_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_dma_req && ae_flag));

    // R7
    one_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !((rx_dma_req || af_flag) && (tx_dma_req || ae_flag)));

    // R8
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!xfer_busy && fill_level == '0)
        |-> !(rx_dma_req || tx_dma_req || af_flag || ae_flag));

    // R10
    rxen_clears_af_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_rxen_bit) |=> !af_flag);

    // R10
    txen_clears_ae_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_txen_bit) |=> !ae_flag);

    // R11
    start_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_start |=> fill_level == '0);
endmodule

bind thresh_fifo thresh_fifo_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .host_wr      (host_wr),
    .host_rd      (host_rd),
    .card_push    (card_push),
    .card_pop     (card_pop),
    .xfer_start   (xfer_start),
    .xfer_busy    (xfer_busy),
    .cfg_we       (cfg_we),
    .cfg_rxen_bit (cfg_wdata[15]),
    .cfg_txen_bit (cfg_wdata[7]),
    .head_word    (head_word),
    .fill_level   (fill_level),
    .rx_dma_req   (rx_dma_req),
    .tx_dma_req   (tx_dma_req),
    .af_flag      (af_flag),
    .ae_flag      (ae_flag)
);

// File: tb/thresh_fifo_bench.sv
module thresh_fifo_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 0, host_rd = 0, card_push = 0, card_pop = 0;
    logic [15:0] host_wdata = 0, card_wdata = 0;
    logic        cfg_we = 0;
    logic [15:0] cfg_wdata = 0;
    logic        xfer_start = 0, xfer_rx = 0, xfer_end = 0;
    logic [15:0] head_word, cfg_rdata;
    logic [5:0]  fill_level;
    logic        rx_dma_req, tx_dma_req, af_flag, ae_flag;

    int    n_chk = 0;
    int    n_err = 0;
    bit    done  = 0;
    string phase = "R1";

    always #4 clk = ~clk;

    thresh_fifo u_thresh_fifo (
        .clk(clk), .rst_n(rst_n),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_rd(host_rd),
        .card_push(card_push), .card_wdata(card_wdata), .card_pop(card_pop),
        .head_word(head_word),
        .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .xfer_start(xfer_start), .xfer_rx(xfer_rx), .xfer_end(xfer_end),
        .fill_level(fill_level),
        .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
        .af_flag(af_flag), .ae_flag(ae_flag)
    );

    // ---------------- behavioural reference ----------------
    logic [15:0] m_q[$];
    logic [15:0] m_mem [32];
    int          m_head, m_tail;
    bit          m_act, m_rx, m_rxen, m_txen;
    int          m_af, m_ae;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_q.delete();
            for (int i = 0; i < 32; i++) m_mem[i] = 16'h0;
            m_head = 0; m_tail = 0; m_act = 0; m_rx = 0;
            m_rxen = 0; m_txen = 0; m_af = 31; m_ae = 0;
        end else begin
            int n;
            n = m_q.size();
            if (xfer_start) begin
                m_q.delete(); m_head = 0; m_tail = 0;
                m_act = 1; m_rx = xfer_rx;
            end else begin
                if (xfer_end) m_act = 0;
                if ((host_rd || card_pop) && n > 0) begin
                    void'(m_q.pop_front());
                    m_head = (m_head + 1) % 32;
                end
                if ((host_wr || card_push) && n < 32) begin
                    logic [15:0] w;
                    w = card_push ? card_wdata : host_wdata;
                    m_q.push_back(w);
                    m_mem[m_tail] = w;
                    m_tail = (m_tail + 1) % 32;
                end
            end
            if (cfg_we) begin
                m_rxen = cfg_wdata[15]; m_af = int'(cfg_wdata[12:8]);
                m_txen = cfg_wdata[7];  m_ae = int'(cfg_wdata[4:0]);
            end
        end
    end

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // compare against the reference every cycle, away from the clock edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int  n;
            bit  rc, tc, qt;
            n  = m_q.size();
            qt = !m_act && n == 0;
            rc = !qt && m_rx && n > m_af;
            tc = !qt && !m_rx && n < m_ae;
            check(phase, "fill_level", 32'(fill_level), 32'(n));
            check(phase, "head_word", 32'(head_word), 32'(m_mem[m_head]));
            check(phase, "rx_dma_req", 32'(rx_dma_req), 32'(rc && m_rxen));
            check(phase, "af_flag", 32'(af_flag), 32'(rc && !m_rxen));
            check(phase, "tx_dma_req", 32'(tx_dma_req), 32'(tc && m_txen));
            check(phase, "ae_flag", 32'(ae_flag), 32'(tc && !m_txen));
            check(phase, "cfg_rdata", 32'(cfg_rdata),
                  32'({m_rxen, 2'b00, 5'(m_af), m_txen, 2'b00, 5'(m_ae)}));
            if (n > 0) check(phase, "head order", 32'(head_word), 32'(m_q[0]));
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        host_wr = 0; host_rd = 0; card_push = 0; card_pop = 0;
        cfg_we = 0; xfer_start = 0; xfer_end = 0;
    endtask

    task automatic hpush(logic [15:0] d);
        host_wr = 1; host_wdata = d; tick();
    endtask

    task automatic cpush(logic [15:0] d);
        card_push = 1; card_wdata = d; tick();
    endtask

    task automatic cfg_write(logic [15:0] d);
        cfg_we = 1; cfg_wdata = d; tick();
    endtask

    task automatic start_xfer(bit rx);
        xfer_start = 1; xfer_rx = rx; tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired actual running expected finished");
        finish_run();
    end

    initial begin
        logic [15:0] keep;
        repeat (3) @(negedge clk);
        check("R1", "reset fill", 32'(fill_level), 32'd0);
        check("R1", "reset cfg", 32'(cfg_rdata), 32'h1F00);
        check("R1", "reset outputs", 32'({rx_dma_req, tx_dma_req, af_flag, ae_flag}), 32'd0);
        rst_n = 1;
        tick();

        phase = "R8";
        cfg_write(16'h1F05);
        check("R8", "idle empty ae_flag", 32'(ae_flag), 32'd0);

        phase = "R6";
        start_xfer(0);
        check("R6", "ae_flag empty tx", 32'(ae_flag), 32'd1);
        for (int i = 0; i < 4; i++) hpush(16'hA000 + 16'(i));
        check("R6", "ae_flag at 4", 32'(ae_flag), 32'd1);
        hpush(16'hA004);
        check("R6", "ae_flag at level", 32'(ae_flag), 32'd0);

        phase = "R10";
        cfg_write(16'h1F85);
        check("R10", "tx_dma_req at level", 32'(tx_dma_req), 32'd0);
        card_pop = 1; tick();
        check("R10", "tx_dma_req below", 32'(tx_dma_req), 32'd1);
        check("R10", "ae_flag with dma", 32'(ae_flag), 32'd0);
        check("R7", "rx side silent", 32'({rx_dma_req, af_flag}), 32'd0);
        check("R2", "head after pop", 32'(head_word), 32'hA001);

        phase = "R3";
        for (int i = 0; i < 28; i++) hpush(16'h1000 + 16'(i));
        check("R3", "fill full", 32'(fill_level), 32'd32);
        hpush(16'hDEAD);
        check("R3", "fill after extra push", 32'(fill_level), 32'd32);
        card_pop = 1; host_wr = 1; host_wdata = 16'hBEEF; tick();
        check("R3", "push with pop at full", 32'(fill_level), 32'd31);

        phase = "R2";
        for (int i = 0; i < 31; i++) begin
            card_pop = 1; tick();
        end
        check("R2", "drained fill", 32'(fill_level), 32'd0);
        check("R6", "tx req when empty and active", 32'(tx_dma_req), 32'd1);

        phase = "R4";
        keep = head_word;
        host_rd = 1; tick();
        check("R4", "empty pop head", 32'(head_word), 32'(keep));
        check("R4", "empty pop fill", 32'(fill_level), 32'd0);
        hpush(16'h5A5A);
        check("R4", "head after push", 32'(head_word), 32'h5A5A);

        phase = "R11";
        start_xfer(1);
        check("R11", "fill after start", 32'(fill_level), 32'd0);

        phase = "R5";
        cfg_write(16'h0300);
        for (int i = 0; i < 3; i++) cpush(16'hC000 + 16'(i));
        check("R5", "af_flag at level", 32'(af_flag), 32'd0);
        cpush(16'hC003);
        check("R5", "af_flag above", 32'(af_flag), 32'd1);
        host_rd = 1; tick();
        check("R5", "af_flag back at level", 32'(af_flag), 32'd0);
        cpush(16'hC004);
        cfg_write(16'h8300);
        check("R10", "af_flag cleared", 32'(af_flag), 32'd0);
        check("R10", "rx_dma_req raised", 32'(rx_dma_req), 32'd1);
        check("R7", "tx side silent", 32'({tx_dma_req, ae_flag}), 32'd0);

        phase = "R12";
        host_wr = 1; host_wdata = 16'h1111; card_push = 1; card_wdata = 16'h2222; tick();
        check("R12", "fill after double push", 32'(fill_level), 32'd5);
        for (int i = 0; i < 4; i++) begin
            host_rd = 1; tick();
        end
        check("R12", "card word kept", 32'(head_word), 32'h2222);

        phase = "R2";
        card_push = 1; card_wdata = 16'h3333; host_rd = 1; tick();
        check("R2", "push+pop fill", 32'(fill_level), 32'd1);
        check("R2", "push+pop head", 32'(head_word), 32'h3333);

        phase = "R8";
        xfer_end = 1; tick();
        cfg_write(16'h8000);
        check("R8", "idle with data requests", 32'(rx_dma_req), 32'd1);
        host_rd = 1; tick();
        check("R8", "idle empty silent", 32'(rx_dma_req), 32'd0);

        phase = "R9";
        cfg_write(16'hFFFF);
        check("R9", "cfg readback", 32'(cfg_rdata), 32'h9F9F);
        cfg_write(16'h1F00);

        phase = "R2 random";
        for (int c = 0; c < 3000; c++) begin
            int r;
            r = $urandom_range(0, 99);
            host_wr    = ($urandom_range(0, 2) == 0);
            host_wdata = 16'($urandom);
            card_push  = ($urandom_range(0, 2) == 0);
            card_wdata = 16'($urandom);
            host_rd    = ($urandom_range(0, 2) == 0);
            card_pop   = ($urandom_range(0, 3) == 0);
            xfer_end   = (r < 2);
            if (r >= 97) begin
                xfer_start = 1;
                xfer_rx    = 1'($urandom);
            end
            if (r >= 2 && r < 5) begin
                cfg_we    = 1;
                cfg_wdata = 16'($urandom);
            end
            tick();
        end

        finish_run();
    end
endmodule